// File: doc/BRIEF.md
# PHY Side-Channel Register Access Sequencer

This block reads and writes 16-bit registers inside a PHY that sits behind a narrow control/status port rather than on a memory bus. One access starts from a simple command: address, write data, a read/write select and a start pulse. The block then works through the handshake phases on its own and finishes with a one-cycle done or error pulse. After a read, the returned data is also available.

Towards the PHY it drives a 20-bit control word and samples a 17-bit status word. Every phase is a complete four-phase exchange. The block raises a capture or strobe bit, polls until acknowledge goes high, drops the bit, and polls until acknowledge goes low. Polling is bounded, so a silent or stuck PHY produces an error and the access is abandoned at once.

Top module: `phy_acc_master`

## Requirements
- R1: Control word layout: bits 15:0 carry the address or data payload, bit 16 requests address capture, bit 17 requests data capture, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at a time, and the whole word is zero while the block is idle.
- R2: Status bit 16 is acknowledge and bits 15:0 are read data. Acknowledge passes through a two-flop synchronizer before it is polled.
- R3: Every access begins with the address phase. The control word takes the values address, then address with bit 16, then address again, each held until acknowledge has risen and then fallen.
- R4: A write continues with these control words in order: data, data with bit 17, data, bit 18 alone, data, then zero. Each capture or strobe word waits for acknowledge high, and each following word waits for acknowledge low. The addressed PHY register then holds the data.
- R5: A read continues with bit 19 alone until acknowledge is high, then a zero word until acknowledge is low. The value on status bits 15:0 at the acknowledge is returned on rdata_o.
- R6: Each acknowledge wait checks the synchronized level up to POLL_MAX times, POLL_GAP cycles apart, starting in the first cycle of the wait. With the defaults (10 checks, 4 cycles apart), an acknowledge that never arrives is declared missing 37 cycles after the capture word appears, give or take no more than one cycle early or two late.
- R7: A timeout in any phase ends the access at once. The control word returns to zero, err_o pulses for one cycle and done_o stays low. This holds both for an acknowledge that never rises and for one that never falls.
- R8: A start pulse while an access is in progress is ignored. The control word sequence of the running access is unchanged.
- R9: done_o and err_o are single-cycle pulses that never occur together, and exactly one of them ends every access.
- R10: rdata_o holds its last read value while idle, even while status bits 15:0 change, until the next read updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one access (taken only when idle) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on acknowledge timeout |
| rdata_o | output | 16 | Data from the most recent read |
| ctrl_o | output | 20 | Control word to the PHY port |
| stat_i | input | 17 | Status word from the PHY port (bit 16 acknowledge) |

## Verification
Some properties are checked on every cycle. The strobe bits are one-hot-or-zero and the control word is zero while idle. A capture request always follows a cycle in which the same address was driven alone. The done and error pulses are single-cycle and exclusive. Read data stays stable while idle, and no access outlasts the worst-case poll budget.

Other behaviour needs the bench's scenarios. These are the exact phase ordering of reads and writes, data landing in the modelled PHY and coming back on a read, and a start during an access being ignored. They also include the timeout window for a silent PHY and the abort on an acknowledge that stays stuck high.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int unsigned CAP_ADR_BIT = 16;
  localparam int unsigned CAP_DAT_BIT = 17;
  localparam int unsigned WR_STB_BIT  = 18;
  localparam int unsigned RD_STB_BIT  = 19;

  typedef enum logic [3:0] {
    S_IDLE, S_A_SET, S_A_CAP, S_A_REL,
    S_W_DAT, S_W_CAP, S_W_CREL, S_W_STB, S_W_SREL,
    S_R_STB, S_R_REL
  } seq_state_e;
endpackage

// File: rtl/phy_ack_sync.sv
module phy_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
  parameter int unsigned MAX_CHECKS = 10,
  parameter int unsigned GAP        = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic want_i,
  input  logic ack_i,
  output logic hit_o,
  output logic tmo_o
);
  localparam int unsigned CW = $clog2(MAX_CHECKS + 1);
  localparam int unsigned GW = $clog2(GAP + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_CHECKS - 1);
  localparam logic [GW-1:0] RELOAD = GW'(GAP - 1);

  logic [CW-1:0] checks_q;
  logic [GW-1:0] gap_q;
  logic          sample;

  assign sample = en_i && (gap_q == '0);
  assign hit_o  = sample && (ack_i == want_i);
  assign tmo_o  = sample && (ack_i != want_i) && (checks_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      checks_q <= '0;
      gap_q    <= '0;
    end else if (!en_i || hit_o || tmo_o) begin
      checks_q <= '0;
      gap_q    <= '0;
    end else if (sample) begin
      checks_q <= checks_q + 1'b1;
      gap_q    <= RELOAD;
    end else begin
      gap_q    <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/phy_acc_master.sv
module phy_acc_master
  import phy_acc_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned POLL_MAX    = 10,
  parameter int unsigned POLL_GAP    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                write_i,
  input  logic [DATA_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W+3:0]   ctrl_o,
  input  logic [DATA_W:0]     stat_i
);
  localparam int unsigned CTRL_W = DATA_W + 4;

  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] addr_q, data_q, rdata_q;
  logic              we_q, done_q, err_q;
  logic              ack_s, poll_en, want, hit, tmo, finish;

  phy_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stat_i[DATA_W]),
    .q_o   (ack_s)
  );

  phy_ack_poller #(.MAX_CHECKS(POLL_MAX), .GAP(POLL_GAP)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (poll_en),
    .want_i(want),
    .ack_i (ack_s),
    .hit_o (hit),
    .tmo_o (tmo)
  );

  always_comb begin
    st_d    = st_q;
    poll_en = 1'b0;
    want    = 1'b0;
    unique case (st_q)
      S_IDLE:   if (start_i) st_d = S_A_SET;
      S_A_SET:  st_d = S_A_CAP;
      S_A_CAP:  begin poll_en = 1'b1; want = 1'b1; if (hit) st_d = S_A_REL; end
      S_A_REL:  begin poll_en = 1'b1; if (hit) st_d = we_q ? S_W_DAT : S_R_STB; end
      S_W_DAT:  st_d = S_W_CAP;
      S_W_CAP:  begin poll_en = 1'b1; want = 1'b1; if (hit) st_d = S_W_CREL; end
      S_W_CREL: begin poll_en = 1'b1; if (hit) st_d = S_W_STB; end
      S_W_STB:  begin poll_en = 1'b1; want = 1'b1; if (hit) st_d = S_W_SREL; end
      S_W_SREL: begin poll_en = 1'b1; if (hit) st_d = S_IDLE; end
      S_R_STB:  begin poll_en = 1'b1; want = 1'b1; if (hit) st_d = S_R_REL; end
      S_R_REL:  begin poll_en = 1'b1; if (hit) st_d = S_IDLE; end
      default:  st_d = S_IDLE;
    endcase
    if (tmo) st_d = S_IDLE;
  end

  assign finish = hit && ((st_q == S_W_SREL) || (st_q == S_R_REL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      err_q  <= tmo;
      if (st_q == S_IDLE && start_i) begin
        addr_q <= addr_i;
        data_q <= wdata_i;
        we_q   <= write_i;
      end
      if (st_q == S_R_STB && hit) rdata_q <= stat_i[DATA_W-1:0];
    end
  end

  // control word is a pure decode of the phase register
  always_comb begin
    ctrl_o = '0;
    unique case (st_q)
      S_A_SET, S_A_REL:             ctrl_o[DATA_W-1:0] = addr_q;
      S_A_CAP:  begin ctrl_o[DATA_W-1:0] = addr_q; ctrl_o[CAP_ADR_BIT] = 1'b1; end
      S_W_DAT, S_W_CREL, S_W_SREL:  ctrl_o[DATA_W-1:0] = data_q;
      S_W_CAP:  begin ctrl_o[DATA_W-1:0] = data_q; ctrl_o[CAP_DAT_BIT] = 1'b1; end
      S_W_STB:  ctrl_o[WR_STB_BIT] = 1'b1;
      S_R_STB:  ctrl_o[RD_STB_BIT] = 1'b1;
      default:  ctrl_o = {CTRL_W{1'b0}};
    endcase
  end

  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/phy_acc_master_chk.sv
module phy_acc_master_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_MAX = 10,
  parameter int unsigned POLL_GAP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W+3:0] ctrl_o
);
  localparam int unsigned LIMIT = 8 * ((POLL_MAX - 1) * POLL_GAP + 1) + 8;
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  a_r1_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_o[DATA_W+3:DATA_W]));
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ctrl_o == '0);
  a_r3_addr_before_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[DATA_W]) |-> $past(ctrl_o[DATA_W-1:0]) == ctrl_o[DATA_W-1:0]);
  a_r6_bounded_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= LIMIT);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r9_end_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(rdata_o));
endmodule

bind phy_acc_master phy_acc_master_chk #(
  .DATA_W(DATA_W), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o),
  .rdata_o(rdata_o),
  .ctrl_o (ctrl_o)
);

// File: tb/sim_phy_acc_master.sv
module sim_phy_acc_master;
  localparam int PM = 10, PG = 4;
  localparam int WD = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic busy, done, err;
  logic [15:0] rdata;
  logic [19:0] ctrl;
  logic [16:0] stat;

  always #4 clk = ~clk;

  phy_acc_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .err_o(err), .rdata_o(rdata), .ctrl_o(ctrl), .stat_i(stat)
  );

  // behavioural PHY: mode 0 normal, 1 silent, 2 ack stuck high
  int mode = 0, lat = 1, lcnt = 0;
  logic ack_raw;
  logic [19:0] pc;
  logic [15:0] paddr, pdata, noise;
  logic [15:0] mem [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_raw <= 1'b0; pc <= '0; paddr <= '0; pdata <= '0; noise <= 16'h0101; lcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      noise <= noise + 16'h1357;
      pc    <= ctrl;
      if (ctrl[16] && !pc[16]) paddr <= ctrl[15:0];
      if (ctrl[17] && !pc[17]) pdata <= ctrl[15:0];
      if (ctrl[18] && !pc[18]) mem[paddr[3:0]] <= pdata;
      if ((|ctrl[19:16]) != ack_raw) begin
        if (lcnt + 1 >= lat) begin ack_raw <= |ctrl[19:16]; lcnt <= 0; end
        else lcnt <= lcnt + 1;
      end else lcnt <= 0;
    end
  end

  assign stat = {(mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : ack_raw,
                 ctrl[19] ? mem[paddr[3:0]] : noise};

  int nchk = 0, nerr = 0, cyc = 0, t_cap = 0;
  logic [19:0] prev_ctrl = '0;
  logic prev_done = 1'b0, prev_err = 1'b0;
  logic [19:0] exp_q[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // one cycle of the reference model, compared at the falling edge
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WD) begin chk(0, "watchdog", cyc, WD); finish_run(); end
    if (ctrl !== prev_ctrl) begin
      if (ctrl[16] && !prev_ctrl[16]) t_cap = cyc;
      if (exp_q.size() == 0) chk(0, "R3 R4 R5 extra control word", ctrl, 0);
      else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        chk(ctrl === e, "R3 R4 R5 control sequence", ctrl, e);
      end
      prev_ctrl = ctrl;
    end
    if ($countones(ctrl[19:16]) > 1) chk(0, "R1 one strobe at a time", ctrl, 0);
    if (!busy && ctrl != 0) chk(0, "R1 idle zero", ctrl, 0);
    if (done && err) chk(0, "R9 exclusive", {done, err}, 2'b00);
    if (done && prev_done) chk(0, "R9 done width", 2, 1);
    if (err && prev_err) chk(0, "R9 err width", 2, 1);
    prev_done = done; prev_err = err;
  endtask

  task automatic access(bit we, logic [15:0] a, logic [15:0] d, bit exp_err,
                        int stop_at, bit win, bit poke, string tag);
    int n;
    bit seen;
    exp_q.push_back({4'b0000, a});
    exp_q.push_back({4'b0001, a});
    if (stop_at >= 2) exp_q.push_back({4'b0000, a});
    if (!exp_err) begin
      if (we) begin
        exp_q.push_back({4'b0000, d});
        exp_q.push_back({4'b0010, d});
        exp_q.push_back({4'b0000, d});
        exp_q.push_back(20'h40000);
        exp_q.push_back({4'b0000, d});
      end else exp_q.push_back(20'h80000);
    end
    exp_q.push_back(20'h0);
    start = 1'b1; wr = we; addr = a; wdata = d;
    tick();
    start = 1'b0;
    n = 0; seen = 0;
    while (!seen && n < 600) begin
      tick(); n++;
      if (poke && n == 6) begin start = 1'b1; wr = ~we; addr = 16'h0F0F; wdata = 16'h1111; end
      if (poke && n == 7) start = 1'b0;
      seen = done || err;
    end
    chk(seen, {tag, " access ended"}, seen, 1);
    chk(err === exp_err, {tag, " R7 err flag"}, err, exp_err);
    chk(done === !exp_err, {tag, " R9 done flag"}, done, !exp_err);
    if (win) chk((cyc - t_cap) >= (PM - 1) * PG && (cyc - t_cap) <= (PM - 1) * PG + 3,
                 {tag, " R6 timeout window"}, cyc - t_cap, (PM - 1) * PG + 1);
    tick();
    chk(!done && !err, {tag, " R9 single pulse"}, {done, err}, 0);
    chk(exp_q.size() == 0, {tag, " R3 sequence complete"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl == 0 && !busy && !done && !err && rdata == 0, "R1 reset state",
        {ctrl, busy, done, err}, 0);
    rst_n = 1'b1;
    tick();
    // R4 write then R5 read back, R2 data through status
    lat = 1;
    access(1, 16'h0A13, 16'h5A5A, 0, 2, 0, 0, "R4 write A");
    access(0, 16'h0A13, 16'h0000, 0, 2, 0, 0, "R5 read A");
    chk(rdata == 16'h5A5A, "R5 R2 readback A", rdata, 16'h5A5A);
    lat = 3;
    access(1, 16'h0B27, 16'hC3C3, 0, 2, 0, 0, "R4 write B slow ack");
    access(0, 16'h0B27, 16'h0000, 0, 2, 0, 0, "R5 read B slow ack");
    chk(rdata == 16'hC3C3, "R5 readback B", rdata, 16'hC3C3);
    // R10 hold while status data churns
    repeat (25) tick();
    chk(rdata == 16'hC3C3, "R10 rdata held", rdata, 16'hC3C3);
    // R8 start during a write is ignored
    lat = 2;
    access(1, 16'h0C34, 16'h9E01, 0, 2, 0, 1, "R8 start while busy");
    access(0, 16'h0C34, 16'h0000, 0, 2, 0, 0, "R8 read after poke");
    chk(rdata == 16'h9E01, "R8 R4 data intact", rdata, 16'h9E01);
    chk(mem[15] == 16'h0000, "R8 poke address untouched", mem[15], 0);
    // R6 R7 silent PHY times out in the address capture wait
    mode = 1;
    access(1, 16'h0D45, 16'h7777, 1, 1, 1, 0, "R6 R7 silent");
    chk(rdata == 16'h9E01, "R10 rdata kept after error", rdata, 16'h9E01);
    // R7 ack stuck high times out on release
    mode = 2;
    access(0, 16'h0E56, 16'h0000, 1, 2, 0, 0, "R7 stuck ack");
    mode = 0; lat = 1;
    repeat (5) tick();
    access(0, 16'h0A13, 16'h0000, 0, 2, 0, 0, "R5 recovery read");
    chk(rdata == 16'h5A5A, "R7 block usable after abort", rdata, 16'h5A5A);
    finish_run();
  end
endmodule